// File: doc/BRIEF.md
# Stochastic Electron Multiplication Emulator

This block generates random output charge counts that follow the statistics of an avalanche gain register. It is meant for producing test patterns. The host loads an input electron count and a per-stage success threshold, then pulses start. The block walks the charge packet through a fixed number of multiplication stages. In every stage, each electron present when the stage begins gets one Bernoulli trial. A successful trial adds one electron to the running total. The decisions come from a 32-bit maximal-length linear feedback shift register, whose value is compared against the threshold.

Each run emulates one pixel. The host repeats runs to build an output distribution. Because the gain is a chain of hundreds of random trials rather than a fixed multiply, a single input electron produces a widely spread output. The host computes the threshold from the desired overall gain: take the gain to the power of one over the stage count, subtract one, and scale the result to the 2^32 random range. Drawing a Poisson input count and keeping histograms are also left to the host.

Top module: `avalanche_gain_emu`

## Requirements
- R1: A start pulse seen while the block is idle, with a nonzero input count, begins a run. busy is high from the cycle after start until the run ends.
- R2: In each of STAGES stages, the number of electrons tested equals the total at stage entry. Electrons added during a stage are tested only in later stages. A trial succeeds when the current generator value, taken as unsigned, is strictly below the threshold latched at start. Each success adds one to the total.
- R3: The total saturates at 2^CNT_W-1. A success at that value sets the overflow output, which stays set for the rest of the run and is cleared by the next accepted start.
- R4: The generator resets to 1. It steps once per trial, after the compare, as a left shift whose new LSB is the XOR of bits 31, 21, 1 and 0. Pulsing seedLoad while idle loads seed, except that a zero seed is ignored and the generator keeps its value.
- R5: A start pulse seen while busy is ignored: its count and threshold do not affect the running result.
- R6: done is a one-cycle pulse in the cycle after the last trial. outCount and overflow then hold stable until the next accepted start.
- R7: An input count of zero gives done in the cycle after start, with outCount 0 and no generator steps.
- R8: A threshold of 0 never succeeds, so outCount equals the input count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| inCount | input | CNT_W | Electron count entering the register |
| threshold | input | 32 | Per-stage success threshold, compared against the generator value |
| seedLoad | input | 1 | Load seed into the generator while idle |
| seed | input | 32 | Generator seed; a zero value is ignored |
| outCount | output | CNT_W | Electron count at the output |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Run in progress |
| overflow | output | 1 | Total saturated during the run |

## Verification
The bench builds the block with STAGES=6 and CNT_W=12. Six stages keep a run to a few thousand cycles. A 12-bit counter can be driven into saturation by a few hundred electrons at a near-certain threshold. Against a bench model of the generator, each run's exact output count is predicted. This brings within reach the zero-input and zero-threshold corners, saturation followed by clearing, ignored zero seeds, and start pulses issued mid-run.

// File: rtl/gain_emu_pkg.sv
package gain_emu_pkg;
  localparam int RND_W = 32;

  typedef struct packed {
    logic seedLd;   // load seed (idle only)
    logic load;     // latch input count and threshold
    logic enter;    // latch stage loop count
    logic test;     // run one electron trial
  } ctrlStrobes_t;
endpackage

// File: rtl/gain_emu_dp.sv
module gain_emu_dp
  import gain_emu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     st,
  input  logic [CNT_W-1:0] inCount,
  input  logic [RND_W-1:0] threshold,
  input  logic [RND_W-1:0] seed,
  output logic [CNT_W-1:0] total,
  output logic             lastElec,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] loopCnt;
  logic [CNT_W-1:0] idx;
  logic [RND_W-1:0] thr;
  logic [RND_W-1:0] lfsr;
  logic [RND_W-1:0] lfsrNext;
  logic             hit;

  assign lfsrNext = {lfsr[RND_W-2:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  assign hit      = lfsr < thr;
  assign lastElec = (idx == loopCnt - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      total    <= '0;
      loopCnt  <= '0;
      idx      <= '0;
      thr      <= '0;
      lfsr     <= 32'h1;
      overflow <= 1'b0;
    end else begin
      if (st.seedLd && seed != '0) lfsr <= seed;
      if (st.load) begin
        total    <= inCount;
        thr      <= threshold;
        overflow <= 1'b0;
      end
      if (st.enter) begin
        loopCnt <= total;
        idx     <= '0;
      end
      if (st.test) begin
        lfsr <= lfsrNext;
        idx  <= idx + 1'b1;
        if (hit) begin
          if (total == CNT_MAX) overflow <= 1'b1;
          else                  total    <= total + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gain_emu_ctrl.sv
module gain_emu_ctrl
  import gain_emu_pkg::*;
#(
  parameter int STAGES = 520,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             seedLoad,
  input  logic [CNT_W-1:0] inCount,
  input  logic             lastElec,
  output ctrlStrobes_t     st,
  output logic             done,
  output logic             busy
);
  localparam int STG_W = $clog2(STAGES + 1);
  localparam logic [STG_W-1:0] LAST_STG = STG_W'(STAGES - 1);

  typedef enum logic [1:0] {S_IDLE, S_ENTER, S_TEST, S_FINISH} state_t;

  state_t           state, stateNext;
  logic [STG_W-1:0] stage;
  logic             idle;

  assign idle = (state == S_IDLE);
  assign busy = (state == S_ENTER) || (state == S_TEST);
  assign done = (state == S_FINISH);

  always_comb begin
    st        = '0;
    stateNext = state;
    case (state)
      S_IDLE: begin
        st.seedLd = seedLoad;
        if (start) begin
          st.load   = 1'b1;
          stateNext = (inCount == '0) ? S_FINISH : S_ENTER;
        end
      end
      S_ENTER: begin
        st.enter  = 1'b1;
        stateNext = S_TEST;
      end
      S_TEST: begin
        st.test = 1'b1;
        if (lastElec) stateNext = (stage == LAST_STG) ? S_FINISH : S_ENTER;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      stage <= '0;
    end else begin
      state <= stateNext;
      if (idle && start) stage <= '0;
      else if (state == S_TEST && lastElec) stage <= stage + 1'b1;
    end
  end
endmodule

// File: rtl/avalanche_gain_emu.sv
module avalanche_gain_emu
  import gain_emu_pkg::*;
#(
  parameter int STAGES = 520,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] inCount,
  input  logic [31:0]      threshold,
  input  logic             seedLoad,
  input  logic [31:0]      seed,
  output logic [CNT_W-1:0] outCount,
  output logic             done,
  output logic             busy,
  output logic             overflow
);
  ctrlStrobes_t st;
  logic         lastElec;

  gain_emu_ctrl #(.STAGES(STAGES), .CNT_W(CNT_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .seedLoad (seedLoad),
    .inCount  (inCount),
    .lastElec (lastElec),
    .st       (st),
    .done     (done),
    .busy     (busy)
  );

  gain_emu_dp #(.CNT_W(CNT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .inCount   (inCount),
    .threshold (threshold),
    .seed      (seed),
    .total     (outCount),
    .lastElec  (lastElec),
    .overflow  (overflow)
  );
endmodule

// File: rtl/avalanche_gain_emu_chk.sv
module avalanche_gain_emu_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [CNT_W-1:0] inCount,
  input logic [CNT_W-1:0] outCount,
  input logic             done,
  input logic             busy,
  input logic             overflow
);
  logic idleNow;
  assign idleNow = !busy && !done;

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (start && idleNow && inCount != '0) |=> busy);

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && outCount == '1) |=> (outCount == '1));

  p_no_overflow_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && overflow) |=> overflow);

  p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_hold_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(start && idleNow)) |=> ($stable(outCount) && $stable(overflow)));

  p_zero_input_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && idleNow && inCount == '0) |=> (done && outCount == '0));

  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));
endmodule

bind avalanche_gain_emu avalanche_gain_emu_chk #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .inCount  (inCount),
  .outCount (outCount),
  .done     (done),
  .busy     (busy),
  .overflow (overflow)
);

// File: tb/test_avalanche_gain_emu.sv
`timescale 1ns/1ps
module test_avalanche_gain_emu;
  localparam int STAGES = 6;
  localparam int CNT_W  = 12;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] inCount = '0;
  logic [31:0]      threshold = '0;
  logic             seedLoad = 1'b0;
  logic [31:0]      seed = '0;
  logic [CNT_W-1:0] outCount;
  logic             done, busy, overflow;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [31:0] mLfsr = 32'h1;

  always #2.5 clk = ~clk;

  avalanche_gain_emu #(.STAGES(STAGES), .CNT_W(CNT_W)) i_avalanche_gain_emu (
    .clk(clk), .rstN(rstN), .start(start), .inCount(inCount),
    .threshold(threshold), .seedLoad(seedLoad), .seed(seed),
    .outCount(outCount), .done(done), .busy(busy), .overflow(overflow)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bench model of one run (R2, R3, R4)
  task automatic model(input int inC, input logic [31:0] thr, output int cnt, output logic ovf);
    cnt = inC;
    ovf = 1'b0;
    for (int s = 0; s < STAGES; s++) begin
      int n = cnt;
      for (int e = 0; e < n; e++) begin
        logic hit = mLfsr < thr;
        mLfsr = {mLfsr[30:0], mLfsr[31] ^ mLfsr[21] ^ mLfsr[1] ^ mLfsr[0]};
        if (hit) begin
          if (cnt == CMAX) ovf = 1'b1;
          else cnt = cnt + 1;
        end
      end
    end
  endtask

  task automatic loadSeed(input logic [31:0] s);
    @(negedge clk);
    seed = s; seedLoad = 1'b1;
    @(negedge clk);
    seedLoad = 1'b0;
    if (s != 0) mLfsr = s;
  endtask

  // Runs one trial; when midStart is set a start with other values is pulsed while busy.
  task automatic trial(input int inC, input logic [31:0] thr, input logic midStart,
                       input string tag, output int lat);
    int expCnt;
    logic expOvf;
    int heldCnt;
    @(negedge clk);
    inCount = CNT_W'(inC); threshold = thr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    model(inC, thr, expCnt, expOvf);
    while (!done) begin
      if (midStart && lat == 3) begin
        inCount = CNT_W'(inC + 17); threshold = 32'hFFFF_FFFF; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat = lat + 1;
    end
    start = 1'b0;
    check(outCount == CNT_W'(expCnt), {tag, " count"}, int'(outCount), expCnt);
    check(overflow == expOvf, {tag, " overflow"}, int'(overflow), int'(expOvf));
    heldCnt = int'(outCount);
    @(negedge clk);
    check(!done, "R6 done pulse width", int'(done), 0);
    repeat (3) @(negedge clk);
    check(int'(outCount) == heldCnt, "R6 count held", int'(outCount), heldCnt);
  endtask

  initial begin
    int lat;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !busy && !overflow && outCount == 0, "R1 reset state",
          int'({done, busy, overflow}), 0);

    // R7: zero input completes in one cycle, no generator steps
    trial(0, 32'hFFFF_FFFF, 1'b0, "R7 zero input", lat);
    check(lat == 1, "R7 latency", lat, 1);

    // R8: zero threshold leaves count unchanged
    trial(37, 32'h0, 1'b0, "R8 zero threshold", lat);

    // R1: busy asserted during a run
    @(negedge clk);
    inCount = 5; threshold = 32'h4000_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R1 busy after start", int'(busy), 1);
    begin
      int c; logic o;
      model(5, 32'h4000_0000, c, o);
      while (!done) @(negedge clk);
      check(outCount == CNT_W'(c), "R2 count after busy run", int'(outCount), c);
      @(negedge clk);
    end

    // R4: seeded runs, and a zero seed is ignored
    loadSeed(32'hACE1_2345);
    trial(3, 32'hC000_0000, 1'b0, "R4 seeded run", lat);
    loadSeed(32'h0);
    trial(4, 32'hC000_0000, 1'b0, "R4 zero seed ignored", lat);

    // R3: saturation then clear on next start
    trial(300, 32'hFFFF_FFFF, 1'b0, "R3 saturation", lat);
    trial(2, 32'h1000_0000, 1'b0, "R3 overflow cleared", lat);

    // R5: start while busy ignored
    trial(9, 32'h6000_0000, 1'b1, "R5 start while busy", lat);

    // R2: single electron at high gain
    trial(1, 32'hE000_0000, 1'b0, "R2 single electron", lat);

    // R2: constrained random runs
    for (int k = 0; k < 16; k++) begin
      int inC = $urandom_range(0, 60);
      logic [31:0] thr = $urandom & 32'h3FFF_FFFF;
      trial(inC, thr, 1'b0, "R2 random run", lat);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule